// File: doc/BRIEF.md
# Serial Control Register Interface

This block is a write-only, three-wire control port. An external controller shifts 8-bit command words in on a data line, one bit per rising edge of a serial clock, most significant bit first. It then raises a latch line to commit the word. The leading bits of each word select one of four internal registers, and the rest of the word carries that register's payload. The registers are a 7-bit attenuation level and three mode-flag groups.

Register selection uses variable-length prefix codes inside the word. There is no separate address phase:
- A leading 0 selects the attenuation register.
- A leading `10` selects mode group 1.
- A leading `11` selects mode group 2 or mode group 3, told apart by the last bit.

All three serial lines are asynchronous to the system clock. They pass through a synchroniser, and edges are detected in the system clock domain.

The port has no data stream, so there is no valid/ready handshake and no back-pressure. The controller paces itself, and a word takes effect a few system clocks after its latch edge. Every decoded field is presented as a plain level output with a defined reset value.

Top module: `serctl_regs`

## Requirements
- R1: The data line is sampled on each rising edge of the serial clock. The first bit of a word (bit 1) lands in word position 7, the MSB, and bit n lands in position 8-n.
- R2: A word is committed only on a rising edge of the latch line after at least 8 bits have arrived. A latch edge after fewer bits leaves every output unchanged.
- R3: A committed word whose bit 1 is 0 sets the attenuation output to bits 2..8 (word[6:0]).
- R4: A committed word starting `10` sets mode group 1: bit 3 jitter_free, bit 4 test_lo, bit 5 high_speed, bit 6 rate_sel_a, bit 7 rate_sel_b, bit 8 deemph_on.
- R5: A committed word starting `11` with bit 8 = 1 sets mode group 2: bit 3 mute_off, bit 4 round_plain, bit 5 out_len24, bit 6 in_len_code[0], bit 7 in_len_code[1].
- R6: A committed word starting `11` with bit 8 = 0 sets mode group 3: bit 3 ovs_a, bit 4 ovs_b, bit 6 test_hi.
- R7: While rst_n is low, the outputs hold their defaults:
  - attenuation 0;
  - jitter_free 1, test_lo 0, high_speed 1, rate_sel_a 1, rate_sel_b 1, deemph_on 0;
  - mute_off 1, round_plain 1, out_len24 0, in_len_code 2'b01;
  - ovs_a 1, ovs_b 1, test_hi 1.
- R8: in_len_bits decodes in_len_code as follows: 2'b11 gives 20, 2'b10 gives 24, 2'b01 gives 16 and 2'b00 gives 32.
- R9: Every latch edge, accepted or not, clears the bit count, so the next word starts at bit 1.
- R10: If more than 8 bits arrive before a latch edge, the last 8 bits form the word.
- R11: A commit changes only the register its prefix selects. Without a commit, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial bit clock (asynchronous) |
| ser_dat | input | 1 | Serial data line |
| ser_latch | input | 1 | Latch line; a rising edge commits the word |
| att_level | output | 7 | Attenuation register value |
| jitter_free | output | 1 | Mode group 1, bit 3 |
| test_lo | output | 1 | Mode group 1, bit 4 |
| high_speed | output | 1 | Mode group 1, bit 5 |
| rate_sel_a | output | 1 | Mode group 1, bit 6 |
| rate_sel_b | output | 1 | Mode group 1, bit 7 |
| deemph_on | output | 1 | Mode group 1, bit 8 |
| mute_off | output | 1 | Mode group 2, bit 3 (1 = muting released) |
| round_plain | output | 1 | Mode group 2, bit 4 |
| out_len24 | output | 1 | Mode group 2, bit 5 |
| in_len_code | output | 2 | {bit 7, bit 6} of mode group 2 |
| in_len_bits | output | 6 | Decoded input word length |
| ovs_a | output | 1 | Mode group 3, bit 3 |
| ovs_b | output | 1 | Mode group 3, bit 4 |
| test_hi | output | 1 | Mode group 3, bit 6 |

## Verification
A bit counter that drifts from word alignment shows up as payload bits shifted by one place in the next committed register. A wrong prefix decode shows up as a write landing in the wrong group, and the untouched outputs of the intended group betray it. Both become visible at the ports within about four system clocks of the latch edge. Bad reset state is visible on every output as soon as rst_n is low. An early-latch leak would alter an output that should have held still.

// File: rtl/serctl_pkg.sv
package serctl_pkg;

  localparam int WORD_W = 8;
  localparam int ATT_W  = 7;

  typedef logic [ATT_W-1:0] att_t;

  typedef struct packed {
    logic jf;
    logic tlo;
    logic hs;
    logic rsa;
    logic rsb;
    logic de;
  } grp1_t;

  typedef struct packed {
    logic mo;
    logic rp;
    logic ow;
    logic il0;
    logic il1;
  } grp2_t;

  typedef struct packed {
    logic oa;
    logic ob;
    logic thi;
  } grp3_t;

  typedef enum logic [1:0] {
    SEL_ATT  = 2'd0,
    SEL_GRP1 = 2'd1,
    SEL_GRP2 = 2'd2,
    SEL_GRP3 = 2'd3
  } sel_e;

  localparam att_t  ATT_RST  = '0;
  localparam grp1_t GRP1_RST = '{jf: 1'b1, tlo: 1'b0, hs: 1'b1, rsa: 1'b1, rsb: 1'b1, de: 1'b0};
  localparam grp2_t GRP2_RST = '{mo: 1'b1, rp: 1'b1, ow: 1'b0, il0: 1'b1, il1: 1'b0};
  localparam grp3_t GRP3_RST = '{oa: 1'b1, ob: 1'b1, thi: 1'b1};

  function automatic logic [5:0] len_decode(input logic [1:0] code);
    case (code)
      2'b11:   return 6'd20;
      2'b10:   return 6'd24;
      2'b01:   return 6'd16;
      default: return 6'd32;
    endcase
  endfunction

endpackage

// File: rtl/serctl_sync.sv
module serctl_sync #(
  parameter int N_LINES = 3,
  parameter int STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] din,
  output logic [N_LINES-1:0] lvl,
  output logic [N_LINES-1:0] rise
);
  localparam int DEPTH = STAGES + 1;

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    logic [DEPTH-1:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '0;
      else        pipe <= {pipe[DEPTH-2:0], din[i]};
    end
    assign lvl[i]  = pipe[STAGES-1];
    assign rise[i] = pipe[STAGES-1] & ~pipe[STAGES];
  end

endmodule

// File: rtl/serctl_shift.sv
module serctl_shift #(
  parameter int WORD_W = 8,
  localparam int CNT_W = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_rise,
  input  logic              bit_val,
  input  logic              latch_rise,
  output logic [WORD_W-1:0] word,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic              full
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WORD_W);

  assign full = (bit_cnt == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word    <= '0;
      bit_cnt <= '0;
    end else if (latch_rise) begin
      bit_cnt <= '0;
    end else if (bit_rise) begin
      word <= {word[WORD_W-2:0], bit_val};
      if (!full) bit_cnt <= bit_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/serctl_decode.sv
module serctl_decode
  import serctl_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              commit,
  input  logic [WORD_W-1:0] word,
  output logic [3:0]        we
);
  sel_e sel;

  always_comb begin
    if (!word[WORD_W-1])      sel = SEL_ATT;
    else if (!word[WORD_W-2]) sel = SEL_GRP1;
    else if (word[0])         sel = SEL_GRP2;
    else                      sel = SEL_GRP3;
  end

  for (genvar k = 0; k < 4; k++) begin : g_we
    assign we[k] = commit && (sel == sel_e'(k));
  end

endmodule

// File: rtl/serctl_store.sv
module serctl_store
  import serctl_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        we,
  input  logic [WORD_W-1:0] word,
  output att_t              att_q,
  output grp1_t             g1_q,
  output grp2_t             g2_q,
  output grp3_t             g3_q
);
  grp1_t g1_d;
  grp2_t g2_d;
  grp3_t g3_d;

  always_comb begin
    g1_d = grp1_t'(word[5:0]);
    g2_d = grp2_t'(word[5:1]);
    g3_d = '{oa: word[5], ob: word[4], thi: word[2]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      att_q <= ATT_RST;
      g1_q  <= GRP1_RST;
      g2_q  <= GRP2_RST;
      g3_q  <= GRP3_RST;
    end else begin
      if (we[SEL_ATT])  att_q <= word[ATT_W-1:0];
      if (we[SEL_GRP1]) g1_q  <= g1_d;
      if (we[SEL_GRP2]) g2_q  <= g2_d;
      if (we[SEL_GRP3]) g3_q  <= g3_d;
    end
  end

endmodule

// File: rtl/serctl_regs.sv
module serctl_regs
  import serctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_clk,
  input  logic             ser_dat,
  input  logic             ser_latch,
  output logic [ATT_W-1:0] att_level,
  output logic             jitter_free,
  output logic             test_lo,
  output logic             high_speed,
  output logic             rate_sel_a,
  output logic             rate_sel_b,
  output logic             deemph_on,
  output logic             mute_off,
  output logic             round_plain,
  output logic             out_len24,
  output logic [1:0]       in_len_code,
  output logic [5:0]       in_len_bits,
  output logic             ovs_a,
  output logic             ovs_b,
  output logic             test_hi
);
  localparam int CNT_W = $clog2(WORD_W + 1);

  logic [2:0]        s_lvl;
  logic [2:0]        s_rise;
  logic [WORD_W-1:0] word;
  logic [CNT_W-1:0]  bit_cnt;
  logic              full;
  logic              commit;
  logic [3:0]        we;
  att_t              att_q;
  grp1_t             g1_q;
  grp2_t             g2_q;
  grp3_t             g3_q;

  // lines: 0 = serial clock, 1 = data, 2 = latch
  serctl_sync #(.N_LINES(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({ser_latch, ser_dat, ser_clk}),
    .lvl  (s_lvl),
    .rise (s_rise)
  );

  serctl_shift #(.WORD_W(WORD_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_rise  (s_rise[0]),
    .bit_val   (s_lvl[1]),
    .latch_rise(s_rise[2]),
    .word      (word),
    .bit_cnt   (bit_cnt),
    .full      (full)
  );

  assign commit = s_rise[2] && full;

  serctl_decode #(.WORD_W(WORD_W)) u_dec (
    .commit(commit),
    .word  (word),
    .we    (we)
  );

  serctl_store #(.WORD_W(WORD_W)) u_store (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (we),
    .word (word),
    .att_q(att_q),
    .g1_q (g1_q),
    .g2_q (g2_q),
    .g3_q (g3_q)
  );

  assign att_level   = att_q;
  assign jitter_free = g1_q.jf;
  assign test_lo     = g1_q.tlo;
  assign high_speed  = g1_q.hs;
  assign rate_sel_a  = g1_q.rsa;
  assign rate_sel_b  = g1_q.rsb;
  assign deemph_on   = g1_q.de;
  assign mute_off    = g2_q.mo;
  assign round_plain = g2_q.rp;
  assign out_len24   = g2_q.ow;
  assign in_len_code = {g2_q.il1, g2_q.il0};
  assign in_len_bits = len_decode(in_len_code);
  assign ovs_a       = g3_q.oa;
  assign ovs_b       = g3_q.ob;
  assign test_hi     = g3_q.thi;

endmodule

// File: rtl/serctl_regs_chk.sv
module serctl_regs_chk #(
  parameter int WORD_W = 8,
  parameter int ATT_W  = 7,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lat_rise,
  input logic              full,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic [3:0]        we,
  input logic [WORD_W-1:0] word,
  input logic [ATT_W-1:0]  att_level,
  input logic [13:0]       flag_bus
);
  assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(WORD_W));

  assert_early_latch_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_rise && !full) |=> ($stable(att_level) && $stable(flag_bus)));

  assert_att_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_rise && full && !word[WORD_W-1]) |=> (att_level == $past(word[ATT_W-1:0])));

  assert_cnt_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lat_rise |=> (bit_cnt == '0));

  assert_single_target_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(we));

  assert_att_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !we[0] |=> $stable(att_level));

endmodule

bind serctl_regs serctl_regs_chk #(
  .WORD_W(serctl_pkg::WORD_W),
  .ATT_W (serctl_pkg::ATT_W),
  .CNT_W ($clog2(serctl_pkg::WORD_W + 1))
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .lat_rise (s_rise[2]),
  .full     (full),
  .bit_cnt  (bit_cnt),
  .we       (we),
  .word     (word),
  .att_level(att_level),
  .flag_bus ({jitter_free, test_lo, high_speed, rate_sel_a, rate_sel_b, deemph_on,
              mute_off, round_plain, out_len24, in_len_code, ovs_a, ovs_b, test_hi})
);

// File: tb/serctl_regs_bench.sv
module serctl_regs_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_latch = 1'b0;
  logic [6:0] att_level;
  logic jitter_free, test_lo, high_speed, rate_sel_a, rate_sel_b, deemph_on;
  logic mute_off, round_plain, out_len24, ovs_a, ovs_b, test_hi;
  logic [1:0] in_len_code;
  logic [5:0] in_len_bits;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  serctl_regs u_serctl_regs (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_latch(ser_latch),
    .att_level(att_level), .jitter_free(jitter_free), .test_lo(test_lo),
    .high_speed(high_speed), .rate_sel_a(rate_sel_a), .rate_sel_b(rate_sel_b),
    .deemph_on(deemph_on), .mute_off(mute_off), .round_plain(round_plain),
    .out_len24(out_len24), .in_len_code(in_len_code), .in_len_bits(in_len_bits),
    .ovs_a(ovs_a), .ovs_b(ovs_b), .test_hi(test_hi)
  );

  // observed state: {att 7, grp1 6, grp2 5, grp3 3}
  logic [20:0] obs;
  assign obs = {att_level, jitter_free, test_lo, high_speed, rate_sel_a, rate_sel_b, deemph_on,
                mute_off, round_plain, out_len24, in_len_code[0], in_len_code[1],
                ovs_a, ovs_b, test_hi};

  localparam logic [20:0] RST_STATE = {7'h00, 6'b101110, 5'b11010, 3'b111};

  // {word 8, expected att 7, grp1 6, grp2 5, grp3 3}, cumulative from reset
  localparam logic [28:0] VECS [7] = '{
    {8'h25,        7'h25, 6'b101110, 5'b11010, 3'b111},  // R3
    {8'b10010011,  7'h25, 6'b010011, 5'b11010, 3'b111},  // R4
    {8'b11001011,  7'h25, 6'b010011, 5'b00101, 3'b111},  // R5
    {8'b11011010,  7'h25, 6'b010011, 5'b00101, 3'b010},  // R6
    {8'h7F,        7'h7F, 6'b010011, 5'b00101, 3'b010},  // R3
    {8'b11110101,  7'h7F, 6'b010011, 5'b11010, 3'b010},  // R5
    {8'b10101100,  7'h7F, 6'b101100, 5'b11010, 3'b010}   // R4
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    ser_dat = b;
    tick(4);
    ser_clk = 1'b1;
    tick(4);
    ser_clk = 1'b0;
  endtask

  task automatic send_word(input logic [7:0] w);
    for (int i = 7; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic pulse_latch();
    tick(2);
    ser_latch = 1'b1;
    tick(4);
    ser_latch = 1'b0;
    tick(6);
  endtask

  task automatic check_state(input logic [20:0] exp, input string req);
    n_checks++;
    if (obs !== exp) begin
      n_fail++;
      $display("FAIL %s: state actual=%h expected=%h", req, obs, exp);
    end
  endtask

  task automatic check_len(input logic [5:0] exp, input string req);
    n_checks++;
    if (in_len_bits !== exp) begin
      n_fail++;
      $display("FAIL %s: in_len_bits actual=%0d expected=%0d", req, in_len_bits, exp);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=expired expected=completion");
      finish_run();
    end
  end

  initial begin
    logic [20:0] st;
    tick(5);
    check_state(RST_STATE, "R7");          // R7 defaults held in reset
    check_len(6'd16, "R7/R8");
    rst_n = 1'b1;
    tick(5);
    check_state(RST_STATE, "R7");

    // table walk: R3 R4 R5 R6 R11
    foreach (VECS[i]) begin
      string tag;
      logic [7:0] w;
      w = VECS[i][28:21];
      tag = !w[7] ? "R3" : (!w[6] ? "R4" : (w[0] ? "R5" : "R6"));
      send_word(w);
      pulse_latch();
      check_state(VECS[i][20:0], {tag, "/R11"});
    end
    st = VECS[6][20:0];

    // R8: all four length codes through mode group 2
    send_word(8'b1111_0_1_1_1); pulse_latch(); check_len(6'd20, "R8 code11");
    send_word(8'b1111_0_0_1_1); pulse_latch(); check_len(6'd24, "R8 code10");
    send_word(8'b1111_0_1_0_1); pulse_latch(); check_len(6'd16, "R8 code01");
    send_word(8'b1111_0_0_0_1); pulse_latch(); check_len(6'd32, "R8 code00");
    st[4:3] = 2'b00;  // il0, il1 now zero

    // R2: 3 bits then latch, nothing changes
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    pulse_latch();
    check_state(st, "R2 early latch");

    // R9: next full word is aligned to bit 1 after the ignored latch
    send_word(8'h11);
    pulse_latch();
    st[20:14] = 7'h11;
    check_state(st, "R9 realign");

    // R2: 8 bits with no latch leaves state unchanged
    send_word(8'h05);
    tick(10);
    check_state(st, "R2 no latch");
    pulse_latch();
    st[20:14] = 7'h05;
    check_state(st, "R1 MSB first");

    // R10: 10 bits, the last 8 form the word
    send_bit(1'b1); send_bit(1'b1);
    send_word(8'h33);
    pulse_latch();
    st[20:14] = 7'h33;
    check_state(st, "R10 overlong");

    // R9/R2: second latch with no new bits is ignored
    pulse_latch();
    check_state(st, "R9 double latch");

    // R7: reset after writes restores defaults
    rst_n = 1'b0;
    tick(3);
    check_state(RST_STATE, "R7 re-reset");
    rst_n = 1'b1;
    tick(3);

    finish_run();
  end

endmodule